// File: doc/BRIEF.md
# Packed SIMD Shift and Compare Unit

This unit carries out packed integer work on a 64-bit source word in a single pipeline stage. A 4-bit opcode selects the operation. The shift operations treat the word as two 32-bit lanes or as four 16-bit lanes. Every lane moves by one shared amount, taken from a scalar operand, and the direction is left, right with sign fill, or right with zero fill.

Two compare operations check four signed 16-bit lanes of two operands, one for greater-than and one for equality. They return one flag per lane, packed into the low bits of the result. A mask-expansion operation turns four bits of the scalar operand into four packed 16-bit lanes, each all-ones or all-zero. This gives masks that the packed selects and blends of a vector datapath can use directly.

The result is captured in a register and appears one cycle after the request. A valid flag marks it.

Top module: `simd_shcmp`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0 and `result` is all zero.
- R2: A request with `in_valid` high at a rising edge produces `out_valid` high after that edge, with the matching `result`. In a cycle without a request, `out_valid` falls to 0 and `result` keeps its last value.
- R3: Opcodes 0, 1 and 2 shift the two 32-bit lanes (bits [31:0] and [63:32] of `src_a`) by `amt[4:0]`. Opcode 0 shifts right with sign fill, opcode 1 shifts right with zero fill, and opcode 2 shifts left with zero fill.
- R4: Opcodes 3, 4 and 5 shift the four 16-bit lanes of `src_a` by `amt[3:0]`. Opcode 3 shifts right with sign fill, opcode 4 shifts right with zero fill, and opcode 5 shifts left with zero fill.
- R5: Bits of `amt` above bit 4 (for 32-bit lanes) or above bit 3 (for 16-bit lanes) have no effect on the result.
- R6: Opcode 6 compares `src_a` against `src_b` as four signed 16-bit lanes. `result[k]` is 1 when lane k of `src_a` is greater than lane k of `src_b`, where lane k is bits [16k+15:16k]. `result[63:4]` is zero.
- R7: Opcode 7 uses the same lane-to-bit packing as R6, but each flag is set on equality of the two lanes. `result[63:4]` is zero.
- R8: Opcode 8 sets `result[16k+15:16k]` to 16'hFFFF when `amt[k]` is 1 and to 16'h0000 when it is 0, for k = 0 to 3. `amt[31:4]` is ignored.
- R9: Opcodes 9 to 15 produce an all-zero result and still raise `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation select |
| src_a | input | 64 | Packed source word, first compare operand |
| src_b | input | 64 | Second compare operand |
| amt | input | 32 | Scalar shift amount or expansion mask |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Registered result |

## Verification
The bench builds the unit with its default parameters: a 64-bit word, a 32-bit scalar operand and a 4-bit opcode. With these values two 32-bit lanes and four 16-bit lanes fit in the word, so every shift amount from 0 to 31 and from 0 to 15 can be swept against lanes whose top bits are set and clear. The same amounts are repeated with junk in the upper bits of the scalar. The compare patterns use lanes at the signed extremes, where a signed compare and an unsigned one disagree.

// File: rtl/simd_shcmp.sv
module simd_shcmp #(
  parameter int WORD_W = 64,
  parameter int AMT_W  = 32,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic [AMT_W-1:0]  amt,
  output logic              out_valid,
  output logic [WORD_W-1:0] result
);
  localparam int N32 = WORD_W / 32;
  localparam int N16 = WORD_W / 16;

  logic [4:0] sh32;
  logic [3:0] sh16;
  assign sh32 = amt[4:0];
  assign sh16 = amt[3:0];

  logic [WORD_W-1:0] sra32, srl32, sll32;
  logic [WORD_W-1:0] sra16, srl16, sll16;
  logic [WORD_W-1:0] gt_w, eq_w, xpnd;
  logic [N16-1:0]    gt_f, eq_f;

  for (genvar i = 0; i < N32; i++) begin : g_l32
    logic [31:0] x;
    assign x = src_a[32*i +: 32];
    assign sra32[32*i +: 32] = $signed(x) >>> sh32;
    assign srl32[32*i +: 32] = x >> sh32;
    assign sll32[32*i +: 32] = x << sh32;
  end

  for (genvar i = 0; i < N16; i++) begin : g_l16
    logic [15:0] x, y;
    assign x = src_a[16*i +: 16];
    assign y = src_b[16*i +: 16];
    assign sra16[16*i +: 16] = $signed(x) >>> sh16;
    assign srl16[16*i +: 16] = x >> sh16;
    assign sll16[16*i +: 16] = x << sh16;
    assign gt_f[i] = $signed(x) > $signed(y);
    assign eq_f[i] = x == y;
    assign xpnd[16*i +: 16] = {16{amt[i]}};
  end

  assign gt_w = {{(WORD_W-N16){1'b0}}, gt_f};
  assign eq_w = {{(WORD_W-N16){1'b0}}, eq_f};

  logic [WORD_W-1:0] nxt;
  always_comb begin
    case (op)
      4'd0:    nxt = sra32;
      4'd1:    nxt = srl32;
      4'd2:    nxt = sll32;
      4'd3:    nxt = sra16;
      4'd4:    nxt = srl16;
      4'd5:    nxt = sll16;
      4'd6:    nxt = gt_w;
      4'd7:    nxt = eq_w;
      4'd8:    nxt = xpnd;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/simd_shcmp_chk.sv
module simd_shcmp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [3:0]  op,
  input logic [31:0] amt,
  input logic        out_valid,
  input logic [63:0] result
);
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  p_gt_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd6) |=> result[63:4] == 60'd0);
  p_eq_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd7) |=> result[63:4] == 60'd0);
  p_expand_lane0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd8) |=> result[15:0] == {16{$past(amt[0])}});
  p_expand_lane3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd8) |=> result[63:48] == {16{$past(amt[3])}});
  p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 4'd8) |=> result == 64'd0);
  p_shl32_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd2 && amt[4:0] != 5'd0) |=> result[0] == 1'b0 && result[32] == 1'b0);
endmodule

bind simd_shcmp simd_shcmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .amt(amt),
  .out_valid(out_valid), .result(result)
);

// File: tb/simd_shcmp_tb.sv
module simd_shcmp_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [31:0] amt = '0;
  logic        out_valid;
  logic [63:0] result;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_shcmp dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .amt(amt),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(input logic [3:0] o, input logic [63:0] a,
                                        input logic [63:0] b, input logic [31:0] m);
    logic [63:0] r;
    int w, s, kind;
    r = '0;
    if (o <= 4'd5) begin
      w    = (o <= 4'd2) ? 32 : 16;
      s    = (o <= 4'd2) ? int'(m[4:0]) : int'(m[3:0]);
      kind = int'(o) % 3;
      for (int base = 0; base < 64; base += w)
        for (int i = 0; i < w; i++) begin
          if (kind == 2) r[base+i] = (i >= s) ? a[base+i-s] : 1'b0;
          else if (i + s < w) r[base+i] = a[base+i+s];
          else r[base+i] = (kind == 0) ? a[base+w-1] : 1'b0;
        end
    end else if (o == 4'd6 || o == 4'd7) begin
      for (int l = 0; l < 4; l++) begin
        int sa, sb;
        sa = int'(a[16*l+15]) * -65536 + int'(a[16*l +: 16]);
        sb = int'(b[16*l+15]) * -65536 + int'(b[16*l +: 16]);
        r[l] = (o == 4'd6) ? (sa > sb) : (sa == sb);
      end
    end else if (o == 4'd8) begin
      for (int l = 0; l < 4; l++) r[16*l +: 16] = m[l] ? 16'hFFFF : 16'h0000;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [3:0] o, input logic [63:0] a,
                       input logic [63:0] b, input logic [31:0] m);
    @(negedge clk);
    op = o; src_a = a; src_b = b; amt = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, result, model(o, a, b, m));
  endtask

  task automatic t_reset_r1();
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 result", result, 64'd0);
  endtask

  task automatic t_shift32_r3();
    for (int s = 0; s < 32; s++)
      for (int k = 0; k < 3; k++) begin
        apply("R3 shift32 neg", 4'(k), 64'h8F00_00F1_7A5C_3C81, '0, 32'(s));
        apply("R3 shift32 pos", 4'(k), 64'h4000_0001_FFFF_FFFF, '0, 32'(s));
      end
  endtask

  task automatic t_shift16_r4();
    for (int s = 0; s < 16; s++)
      for (int k = 3; k < 6; k++)
        apply("R4 shift16", 4'(k), 64'h8001_7FFE_C35A_0F0F, '0, 32'(s));
  endtask

  task automatic t_amt_upper_r5();
    for (int s = 0; s < 32; s += 7) begin
      apply("R5 shift32 upper junk", 4'd0, 64'hF0F0_1234_8000_0001, '0, 32'hDEAD_BEE0 | 32'(s));
      apply("R5 shift16 upper junk", 4'd4, 64'hF0F0_1234_8000_0001, '0, 32'hDEAD_BEF0 | 32'(s % 16));
    end
  endtask

  task automatic t_cmp_gt_r6();
    apply("R6 gt extremes", 4'd6, 64'h7FFF_0000_0001_8000, 64'h8000_FFFF_0001_7FFF, '0);
    apply("R6 gt lanes", 4'd6, 64'h0005_FFFE_0010_0002, 64'h0004_FFFF_0010_0001, '0);
    check("R6 gt packing", result, 64'h0000_0000_0000_0009);
    apply("R6 gt all", 4'd6, 64'h0001_0001_0001_0001, 64'hFFFF_FFFF_FFFF_FFFF, '0);
  endtask

  task automatic t_cmp_eq_r7();
    apply("R7 eq mixed", 4'd7, 64'h1234_8000_FFFF_0000, 64'h1234_7FFF_FFFF_0001, '0);
    check("R7 eq packing", result, 64'h0000_0000_0000_000A);
    apply("R7 eq all", 4'd7, 64'hABCD_ABCD_ABCD_ABCD, 64'hABCD_ABCD_ABCD_ABCD, '0);
  endtask

  task automatic t_expand_r8();
    for (int m = 0; m < 16; m++)
      apply("R8 expand", 4'd8, 64'h1111_2222_3333_4444, '1, 32'hFFFF_FFF0 | 32'(m));
    apply("R8 expand 5", 4'd8, '0, '0, 32'h0000_0005);
    check("R8 expand 5 value", result, 64'h0000_FFFF_0000_FFFF);
  endtask

  task automatic t_undef_r9();
    for (int o = 9; o < 16; o++)
      apply("R9 undefined", 4'(o), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 32'hFFFF_FFFF);
  endtask

  task automatic t_hold_r2();
    logic [63:0] held;
    apply("R2 load", 4'd2, 64'h0000_0001_0000_0003, '0, 32'd4);
    held = result;
    @(negedge clk);
    src_a = '1; op = 4'd8; amt = '1;
    @(negedge clk);
    check("R2 idle valid low", {63'd0, out_valid}, 64'd0);
    check("R2 idle hold", result, held);
    check("R2 load value", held, 64'h0000_0010_0000_0030);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_shift32_r3();
    t_shift16_r4();
    t_amt_upper_r5();
    t_cmp_gt_r6();
    t_cmp_eq_r7();
    t_expand_r8();
    t_undef_r9();
    t_hold_r2();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule